// File: doc/BRIEF.md
# Offset-Coded Programmable Synthesizer Dividers

This block holds the two integer dividers that sit in front of the phase comparator of a clock-synthesizer loop. The reference path counts cycles of the input clock and divides by its 7-bit word plus two. The feedback path counts cycles of the oscillator clock in two stages: a counter that divides by its 9-bit word plus eight, then a divide-by-two stage. Each path emits a single-cycle pulse on its own clock when it reaches terminal count.

The words arrive as static straps and may change at any time. Each divider takes its word only at the end of a period, so a change never produces a shortened period. A variant input chooses the strict or open rule set. Under the strict rules a few small words are refused: the error flag of that path goes high and the divider keeps its last accepted ratio. An active-low power-down clears both paths at once. After power-down releases, each path runs one period with the all-ones word, which is what undriven straps with pull-ups read as.

Top module: `pll_offset_dividers`

## Requirements
- R1: With an accepted reference word W (0..127), `ref_pulse` rises once every W+2 cycles of `ref_clk`.
- R2: With an accepted feedback word W (0..511), `fb_pulse` rises once every 2*(W+8) cycles of `vco_clk`.
- R3: Each pulse output is high for exactly one cycle of its own clock.
- R4: A path samples its word only on the clock edge that raises its pulse. A word value present on any other edge has no effect on any period.
- R5: With `strict` = 1, reference word 0 and feedback words 0, 1, 2 and 3 are refused. When a refused word is sampled, that path's error flag goes to 1 together with the pulse and the ratio stays unchanged. A sampled accepted word clears the flag. The flag changes only on edges that raise the pulse.
- R6: With `strict` = 0, every word is accepted and the error flags read 0. Word 0 gives a reference period of 2 and a feedback period of 16.
- R7: While `pd_n` is 0, both pulses and both error flags are 0 and both counters are cleared, asynchronously. After release, each path's first period uses the all-ones word (129 reference cycles, 1038 oscillator cycles), whatever the word inputs are. The words are first sampled at the end of that period.
- R8: A reference word of 59 gives a period of 61, and a feedback word of 276 gives a period of 568.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Input (crystal or clock) domain clock |
| vco_clk | input | 1 | Oscillator domain clock |
| pd_n | input | 1 | Active-low power-down, asynchronous clear of both paths |
| strict | input | 1 | Variant select: 1 = strict word rules, 0 = open rules |
| ref_word | input | 7 | Reference divider word |
| fb_word | input | 9 | Feedback divider word |
| ref_pulse | output | 1 | Terminal-count pulse of the reference path (ref_clk domain) |
| fb_pulse | output | 1 | Terminal-count pulse of the feedback path (vco_clk domain) |
| ref_err | output | 1 | Refused reference word flag (ref_clk domain) |
| fb_err | output | 1 | Refused feedback word flag (vco_clk domain) |

## Verification
The bench puts the illegal word 0 on the word input for part of every period. A design that samples the word at any point other than terminal count would show a wrong period, and under strict rules it would also raise a flag. Refused words are followed by a check that the period stays at the previously accepted ratio, so a design that loads the refused word would show a period of 2 or 16 to 22. Power-down is entered while both flags are high and while the word inputs hold refused values. A design that did not clear the flags, or that restarted from the word inputs instead of the all-ones word, would give a wrong first period after release. The smallest ratios (2 and 16) are run to expose off-by-one counter ends, and the feedback period shows whether the divide-by-two stage is there.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

   typedef enum logic {
      VAR_OPEN   = 1'b0,
      VAR_STRICT = 1'b1
   } variant_e;

   localparam int REF_W_DEF   = 7;
   localparam int REF_OFS_DEF = 2;
   localparam int REF_MIN_DEF = 1;
   localparam int FB_W_DEF    = 9;
   localparam int FB_OFS_DEF  = 8;
   localparam int FB_MIN_DEF  = 4;

   // counter width able to hold max ratio for a word width and offset
   function automatic int cnt_width(input int word_w, input int ofs);
      return $clog2((1 << word_w) + ofs);
   endfunction

endpackage

// File: rtl/pll_word_gate.sv
module pll_word_gate #(
   parameter int WORD_W     = 7,
   parameter int MIN_STRICT = 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic              strict_en,
   output logic              legal
);

   if (MIN_STRICT < 1 || MIN_STRICT >= (1 << WORD_W)) begin : g_bad_min
      $error("pll_word_gate: MIN_STRICT out of range");
   end

   localparam logic [WORD_W-1:0] LIMIT = WORD_W'(MIN_STRICT);

   assign legal = !(strict_en && (word < LIMIT));

endmodule

// File: rtl/pll_div_cell.sv
module pll_div_cell #(
   parameter int WORD_W     = 7,
   parameter int OFFSET     = 2,
   parameter int MIN_STRICT = 1,
   parameter bit HALVE      = 1'b0
) (
   input  logic              clk,
   input  logic              pd_n,
   input  logic              strict_en,
   input  logic [WORD_W-1:0] word,
   output logic              tick,
   output logic              err
);

   if (WORD_W < 2) begin : g_bad_w
      $error("pll_div_cell: WORD_W must be at least 2");
   end
   if (OFFSET < 1) begin : g_bad_ofs
      $error("pll_div_cell: OFFSET must be at least 1");
   end

   localparam int CNT_W = pll_div_pkg::cnt_width(WORD_W, OFFSET);
   localparam logic [CNT_W-1:0] OFS_M1 = CNT_W'(OFFSET - 1);

   logic [WORD_W-1:0] hold_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_cnt;
   logic              base_end;
   logic              period_end;
   logic              legal;

   pll_word_gate #(
      .WORD_W     (WORD_W),
      .MIN_STRICT (MIN_STRICT)
   ) u_gate (
      .word      (word),
      .strict_en (strict_en),
      .legal     (legal)
   );

   assign last_cnt = CNT_W'(hold_q) + OFS_M1;
   assign base_end = (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge pd_n) begin
      if (!pd_n) begin
         cnt_q <= '0;
      end else if (base_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (HALVE) begin : g_halve
      logic half_q;
      always_ff @(posedge clk or negedge pd_n) begin
         if (!pd_n) begin
            half_q <= 1'b0;
         end else if (base_end) begin
            half_q <= ~half_q;
         end
      end
      assign period_end = base_end & half_q;
   end else begin : g_direct
      assign period_end = base_end;
   end

   always_ff @(posedge clk or negedge pd_n) begin
      if (!pd_n) begin
         hold_q <= '1;
         err    <= 1'b0;
         tick   <= 1'b0;
      end else begin
         tick <= period_end;
         if (period_end) begin
            err <= !legal;
            if (legal) begin
               hold_q <= word;
            end
         end
      end
   end

endmodule

// File: rtl/pll_offset_dividers.sv
module pll_offset_dividers #(
   parameter int REF_W   = pll_div_pkg::REF_W_DEF,
   parameter int REF_OFS = pll_div_pkg::REF_OFS_DEF,
   parameter int REF_MIN = pll_div_pkg::REF_MIN_DEF,
   parameter int FB_W    = pll_div_pkg::FB_W_DEF,
   parameter int FB_OFS  = pll_div_pkg::FB_OFS_DEF,
   parameter int FB_MIN  = pll_div_pkg::FB_MIN_DEF
) (
   input  logic             ref_clk,
   input  logic             vco_clk,
   input  logic             pd_n,
   input  logic             strict,
   input  logic [REF_W-1:0] ref_word,
   input  logic [FB_W-1:0]  fb_word,
   output logic             ref_pulse,
   output logic             fb_pulse,
   output logic             ref_err,
   output logic             fb_err
);

   pll_div_pkg::variant_e var_sel;
   logic                  strict_en;

   assign var_sel   = pll_div_pkg::variant_e'(strict);
   assign strict_en = (var_sel == pll_div_pkg::VAR_STRICT);

   pll_div_cell #(
      .WORD_W     (REF_W),
      .OFFSET     (REF_OFS),
      .MIN_STRICT (REF_MIN),
      .HALVE      (1'b0)
   ) u_ref (
      .clk       (ref_clk),
      .pd_n      (pd_n),
      .strict_en (strict_en),
      .word      (ref_word),
      .tick      (ref_pulse),
      .err       (ref_err)
   );

   pll_div_cell #(
      .WORD_W     (FB_W),
      .OFFSET     (FB_OFS),
      .MIN_STRICT (FB_MIN),
      .HALVE      (1'b1)
   ) u_fb (
      .clk       (vco_clk),
      .pd_n      (pd_n),
      .strict_en (strict_en),
      .word      (fb_word),
      .tick      (fb_pulse),
      .err       (fb_err)
   );

endmodule

// File: rtl/pll_offset_dividers_chk.sv
module pll_offset_dividers_chk #(
   parameter int REF_W   = 7,
   parameter int FB_W    = 9,
   parameter int REF_MIN = 1,
   parameter int FB_MIN  = 4
) (
   input logic             ref_clk,
   input logic             vco_clk,
   input logic             pd_n,
   input logic             strict,
   input logic [REF_W-1:0] ref_word,
   input logic [FB_W-1:0]  fb_word,
   input logic             ref_pulse,
   input logic             fb_pulse,
   input logic             ref_err,
   input logic             fb_err
);

   a_r3_ref_single: assert property (@(posedge ref_clk) disable iff (!pd_n)
      ref_pulse |=> !ref_pulse);

   a_r3_fb_single: assert property (@(posedge vco_clk) disable iff (!pd_n)
      fb_pulse |=> !fb_pulse);

   a_r5_ref_refused: assert property (@(posedge ref_clk) disable iff (!pd_n)
      (ref_pulse && $past(strict) && ($past(ref_word) < REF_W'(REF_MIN))) |-> ref_err);

   a_r5_fb_refused: assert property (@(posedge vco_clk) disable iff (!pd_n)
      (fb_pulse && $past(strict) && ($past(fb_word) < FB_W'(FB_MIN))) |-> fb_err);

   a_r5_ref_flag_steady: assert property (@(posedge ref_clk) disable iff (!pd_n)
      !ref_pulse |-> $stable(ref_err));

   a_r5_fb_flag_steady: assert property (@(posedge vco_clk) disable iff (!pd_n)
      !fb_pulse |-> $stable(fb_err));

   a_r6_ref_open: assert property (@(posedge ref_clk) disable iff (!pd_n)
      (ref_pulse && !$past(strict)) |-> !ref_err);

   a_r6_fb_open: assert property (@(posedge vco_clk) disable iff (!pd_n)
      (fb_pulse && !$past(strict)) |-> !fb_err);

   a_r7_pd_quiet: assert property (@(posedge ref_clk)
      !pd_n |-> (!ref_pulse && !ref_err && !fb_pulse && !fb_err));

endmodule

bind pll_offset_dividers pll_offset_dividers_chk #(
   .REF_W   (REF_W),
   .FB_W    (FB_W),
   .REF_MIN (REF_MIN),
   .FB_MIN  (FB_MIN)
) u_chk (.*);

// File: tb/sim_pll_offset_dividers.sv
`timescale 1ns/1ps
module sim_pll_offset_dividers;

   typedef struct {
      int    per;
      string tag;
   } exp_t;

   logic       ref_clk = 1'b0;
   logic       vco_clk = 1'b0;
   logic       pd_n;
   logic       strict;
   logic [6:0] ref_word;
   logic [8:0] fb_word;
   logic       ref_pulse, fb_pulse, ref_err, fb_err;

   int   checks = 0;
   int   bad    = 0;
   bit   mon_on = 1'b0;
   int   ref_cnt = 0;
   int   fb_cnt  = 0;
   int   ref_hold = 127;
   int   fb_hold  = 511;
   exp_t ref_q[$];
   exp_t fb_q[$];
   exp_t ref_last = '{129, "R7"};
   exp_t fb_last  = '{1038, "R7"};

   always #10 ref_clk = ~ref_clk;   // 50 MHz
   always #5  vco_clk = ~vco_clk;   // 100 MHz oscillator side

   pll_offset_dividers u0 (
      .ref_clk   (ref_clk),
      .vco_clk   (vco_clk),
      .pd_n      (pd_n),
      .strict    (strict),
      .ref_word  (ref_word),
      .fb_word   (fb_word),
      .ref_pulse (ref_pulse),
      .fb_pulse  (fb_pulse),
      .ref_err   (ref_err),
      .fb_err    (fb_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: reference periods
   initial forever begin
      @(posedge ref_clk);
      if (!pd_n) ref_cnt = 0; else ref_cnt++;
      @(negedge ref_clk);
      if (pd_n && mon_on && ref_pulse) begin
         if (ref_q.size() > 0) ref_last = ref_q.pop_front();
         chk(ref_cnt == ref_last.per, ref_last.tag, "ref period", ref_cnt, ref_last.per);
         ref_cnt = 0;
      end
   end

   // monitor: feedback periods
   initial forever begin
      @(posedge vco_clk);
      if (!pd_n) fb_cnt = 0; else fb_cnt++;
      @(negedge vco_clk);
      if (pd_n && mon_on && fb_pulse) begin
         if (fb_q.size() > 0) fb_last = fb_q.pop_front();
         chk(fb_cnt == fb_last.per, fb_last.tag, "fb period", fb_cnt, fb_last.per);
         fb_cnt = 0;
      end
   end

   // driver: junk word 0 for a cycle (R4), then real word, wait for capture
   task automatic ref_step(input int w, input string tag);
      bit ok;
      ref_word = 7'd0;
      @(negedge ref_clk); #1;
      ref_word = 7'(w);
      @(negedge ref_clk iff ref_pulse); #1;
      ok = !(strict && w < 1);
      chk(ref_err == !ok, tag, "ref_err after capture", int'(ref_err), int'(!ok));
      if (ok) ref_hold = w;
      ref_q.push_back('{ref_hold + 2, tag});
   endtask

   task automatic fb_step(input int w, input string tag);
      bit ok;
      fb_word = 9'd0;
      @(negedge vco_clk); #1;
      fb_word = 9'(w);
      @(negedge vco_clk iff fb_pulse); #1;
      ok = !(strict && w < 4);
      chk(fb_err == !ok, tag, "fb_err after capture", int'(fb_err), int'(!ok));
      if (ok) fb_hold = w;
      fb_q.push_back('{2 * (fb_hold + 8), tag});
   endtask

   task automatic quiet_check(input string tag);
      chk(ref_pulse == 1'b0, tag, "ref_pulse in power-down", int'(ref_pulse), 0);
      chk(fb_pulse == 1'b0, tag, "fb_pulse in power-down", int'(fb_pulse), 0);
      chk(ref_err == 1'b0, tag, "ref_err in power-down", int'(ref_err), 0);
      chk(fb_err == 1'b0, tag, "fb_err in power-down", int'(fb_err), 0);
   endtask

   initial begin
      repeat (150000) @(posedge ref_clk);
      checks++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      pd_n     = 1'b1;
      strict   = 1'b0;
      ref_word = 7'd59;
      fb_word  = 9'd276;
      #2 pd_n  = 1'b0;
      repeat (3) @(negedge ref_clk);
      quiet_check("R7");
      #1 pd_n  = 1'b1;
      mon_on   = 1'b1;

      // open rules: R1 R2 R6 R8, first period all-ones R7
      fork
         begin
            ref_step(59, "R8");
            ref_step(0, "R6");
            ref_step(127, "R1");
            ref_step(5, "R1");
            ref_step(59, "R8");
         end
         begin
            fb_step(276, "R8");
            fb_step(0, "R6");
            fb_step(3, "R6");
            fb_step(511, "R2");
            fb_step(276, "R8");
         end
      join

      @(negedge ref_clk); #1 strict = 1'b1;

      // strict rules: R5, ending with refused words so flags are high
      fork
         begin
            ref_step(0, "R5");
            ref_step(1, "R5");
            ref_step(0, "R5");
            ref_step(59, "R8");
            ref_step(0, "R5");
         end
         begin
            fb_step(3, "R5");
            fb_step(4, "R5");
            fb_step(1, "R5");
            fb_step(2, "R5");
            fb_step(276, "R8");
            fb_step(0, "R5");
         end
      join

      // power-down with flags set and refused words on the inputs (R7)
      @(negedge ref_clk); #1 pd_n = 1'b0;
      ref_q.delete();
      fb_q.delete();
      ref_hold = 127;
      fb_hold  = 511;
      ref_last = '{129, "R7"};
      fb_last  = '{1038, "R7"};
      repeat (3) @(negedge ref_clk);
      quiet_check("R7");
      #1 pd_n = 1'b1;

      fork
         begin
            ref_step(0, "R7");
            ref_step(10, "R1");
            @(negedge ref_clk iff ref_pulse);
         end
         begin
            fb_step(0, "R7");
            fb_step(10, "R2");
            @(negedge vco_clk iff fb_pulse);
         end
      join
      #2;
      mon_on = 1'b0;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule